// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block is the timing engine of a display pipeline. Clocked by the pixel clock, it runs a horizontal pixel counter and a vertical line counter. From them it derives hsync, vsync, a display-active window and a one-cycle prefetch strobe that fires a programmable number of pixels before each line ends. Software sets every boundary through a small write/read register port. Each timing register holds a last-index value, that is, a count minus one. For a mode with `xres` visible pixels and front porch `fp`, the horizontal total register gets `total-1`, the width register gets `xres-1`, sync start gets `xres+fp-1` and sync end gets `xres+fp+len-1`. The vertical registers are filled in the same way.

A control register has two separate bits. One enables the generator. The other enables screen refresh, which gates the display window and the prefetch strobe. Software clears both bits before it reprograms the timing and sets them again afterwards. An output stage applies per-sync polarity inversion and per-sync suppression, which gives suspend and power-down blanking. It also carries a sync-on-RGB flag and a display-off flag. A second compare register for the end of hsync is also provided; the hsync pulse ends at whichever of the two end compares comes first.

Top module: `raster_timing_gen`

## Requirements
- R1: Register addresses are: 0 control, 1 horizontal total, 2 display width, 3 hsync start, 4 hsync end, 5 second hsync end, 6 vertical total, 7 display height, 8 vsync start, 9 vsync end, 10 prefetch point, 11 sync control, 12 display control. Every register resets to zero, reads back what was written, and sync-control bit 2 always reads 0.
- R2: While control bit 0 (enable) is clear, both counters are held at zero and hsync and vsync stay at their inactive level after inversion. After enable is set, hsync first asserts `hsync_start+1` cycles after the clock edge that writes the control register, because the outputs are registered.
- R3: A line lasts `h_total+1` cycles. The vertical counter advances when the horizontal counter wraps from `h_total`. A frame holds `v_total+1` lines.
- R4: Before inversion, hsync is high while the horizontal counter lies between the start value and the smaller of the two end values, both ends included.
- R5: Before inversion, vsync is high for whole lines whose number lies between the vsync start and end values, both ends included.
- R6: `disp_active_o` is high only when enable and control bit 1 (refresh) are both set, the horizontal counter is at most the width register, and the vertical counter is at most the height register.
- R7: `prefetch_o` pulses for one cycle per line when the horizontal counter equals the prefetch point, and only while enable and refresh are set.
- R8: Sync-control bit 3 inverts hsync and bit 4 inverts vsync.
- R9: Sync-control bit 5 suppresses hsync, bit 6 suppresses vsync, and bit 1 suppresses both. A suppressed sync sits at its inactive level, which is the value of its inversion bit.
- R10: Display-control bit 1 forces `video_on_o` low and leaves `disp_active_o` untouched. Otherwise `video_on_o` equals `disp_active_o`. Sync-control bit 0 appears on `sync_on_rgb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| hsync_o | output | 1 | Horizontal sync after suppression and inversion |
| vsync_o | output | 1 | Vertical sync after suppression and inversion |
| disp_active_o | output | 1 | Inside the visible window |
| video_on_o | output | 1 | Visible window with display-off applied |
| prefetch_o | output | 1 | Early end-of-line fetch strobe |
| sync_on_rgb_o | output | 1 | Sync-on-RGB flag |

## Verification
The bench builds the block with CNT_W=12, ADDR_W=4 and DATA_W=32. With a 12-bit counter, the full 1688-pixel default line fits: 1280 visible pixels, hsync from 1327 to 1439, and prefetch at 1332. The vertical total is cut to 12 lines, so a whole frame takes about 20k cycles, and line period, sync widths and per-frame active counts can be measured in full. Small random geometries drawn from a fixed seed exercise short porches and single-line syncs. Because the measurement windows are short, the bench can also cover every suppression and inversion bit, the refresh and enable gating, and the second end compare.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int MAX_CNT_W = 16;
    localparam int NUM_TIM   = 10;

    typedef enum logic [3:0] {
        RA_CTRL     = 4'd0,
        RA_SYNC     = 4'd11,
        RA_DISP     = 4'd12
    } reg_addr_e;

    // timing register indices; register address = index + 1
    localparam int TI_H_TOTAL  = 0;
    localparam int TI_H_DISP   = 1;
    localparam int TI_HS_BEG   = 2;
    localparam int TI_HS_FIN   = 3;
    localparam int TI_HS_FIN2  = 4;
    localparam int TI_V_TOTAL  = 5;
    localparam int TI_V_DISP   = 6;
    localparam int TI_VS_BEG   = 7;
    localparam int TI_VS_FIN   = 8;
    localparam int TI_PREFETCH = 9;

    typedef struct packed {
        logic refresh;   // bit 1
        logic enable;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic v_off;     // bit 6
        logic h_off;     // bit 5
        logic v_inv;     // bit 4
        logic h_inv;     // bit 3
        logic spare;     // bit 2, not stored
        logic all_off;   // bit 1
        logic on_rgb;    // bit 0
    } sync_cfg_t;

    localparam logic [6:0] SYNC_WR_MASK = 7'b111_1011;

    function automatic logic in_span(input logic [MAX_CNT_W-1:0] p,
                                     input logic [MAX_CNT_W-1:0] s,
                                     input logic [MAX_CNT_W-1:0] e,
                                     input logic [MAX_CNT_W-1:0] e2);
        return (p >= s) && (p <= e) && (p <= e2);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output sync_cfg_t         sync_cfg,
    output logic              disp_off,
    output logic [CNT_W-1:0]  tim [NUM_TIM]
);

    logic [CNT_W-1:0] tim_q [NUM_TIM];
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i + 1))
                tim_q[i] <= wr_data[CNT_W-1:0];
        end
        assign tim[i] = tim_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            sync_cfg <= '0;
            disp_off <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(RA_CTRL))
                ctrl <= ctrl_t'(wr_data[1:0]);
            if (wr_addr == ADDR_W'(RA_SYNC))
                sync_cfg <= sync_cfg_t'(wr_data[6:0] & SYNC_WR_MASK);
            if (wr_addr == ADDR_W'(RA_DISP))
                disp_off <= wr_data[1];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(RA_CTRL))
            rd_data[1:0] = ctrl;
        if (rd_addr == ADDR_W'(RA_SYNC))
            rd_data[6:0] = sync_cfg;
        if (rd_addr == ADDR_W'(RA_DISP))
            rd_data[1] = disp_off;
        for (int i = 0; i < NUM_TIM; i++)
            if (rd_addr == ADDR_W'(i + 1))
                rd_data[CNT_W-1:0] = tim_q[i];
    end

endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_cnt == h_total) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == v_total) ? '0 : v_cnt + CNT_W'(1);
        end else begin
            h_cnt <= h_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rtg_outstage.sv
module rtg_outstage
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  sync_cfg_t        sync_cfg,
    input  logic             disp_off,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic [CNT_W-1:0] tim [NUM_TIM],
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             disp_active_o,
    output logic             video_on_o,
    output logic             prefetch_o,
    output logic             sync_on_rgb_o
);

    localparam int AXES = 2;   // 0 horizontal, 1 vertical

    logic [CNT_W-1:0] pos  [AXES];
    logic [CNT_W-1:0] beg  [AXES];
    logic [CNT_W-1:0] fin  [AXES];
    logic [CNT_W-1:0] fin2 [AXES];
    logic [AXES-1:0]  raw, kill, inv, level;
    logic             active_d, strobe_d, unused_spare;

    assign unused_spare = sync_cfg.spare;

    assign pos[0]  = h_cnt;
    assign beg[0]  = tim[TI_HS_BEG];
    assign fin[0]  = tim[TI_HS_FIN];
    assign fin2[0] = tim[TI_HS_FIN2];
    assign kill[0] = sync_cfg.h_off | sync_cfg.all_off;
    assign inv[0]  = sync_cfg.h_inv;

    assign pos[1]  = v_cnt;
    assign beg[1]  = tim[TI_VS_BEG];
    assign fin[1]  = tim[TI_VS_FIN];
    assign fin2[1] = tim[TI_VS_FIN];
    assign kill[1] = sync_cfg.v_off | sync_cfg.all_off;
    assign inv[1]  = sync_cfg.v_inv;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        assign raw[a]   = ctrl.enable &&
                          in_span(MAX_CNT_W'(pos[a]), MAX_CNT_W'(beg[a]),
                                  MAX_CNT_W'(fin[a]), MAX_CNT_W'(fin2[a]));
        assign level[a] = (raw[a] & ~kill[a]) ^ inv[a];
    end

    assign active_d = ctrl.enable && ctrl.refresh &&
                      (h_cnt <= tim[TI_H_DISP]) && (v_cnt <= tim[TI_V_DISP]);
    assign strobe_d = ctrl.enable && ctrl.refresh && (h_cnt == tim[TI_PREFETCH]);

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_o       <= 1'b0;
            vsync_o       <= 1'b0;
            disp_active_o <= 1'b0;
            video_on_o    <= 1'b0;
            prefetch_o    <= 1'b0;
            sync_on_rgb_o <= 1'b0;
        end else begin
            hsync_o       <= level[0];
            vsync_o       <= level[1];
            disp_active_o <= active_d;
            video_on_o    <= active_d & ~disp_off;
            prefetch_o    <= strobe_d;
            sync_on_rgb_o <= sync_cfg.on_rgb;
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              disp_active_o,
    output logic              video_on_o,
    output logic              prefetch_o,
    output logic              sync_on_rgb_o
);

    ctrl_t            ctrl;
    sync_cfg_t        sync_cfg;
    logic             disp_off;
    logic [CNT_W-1:0] tim [NUM_TIM];
    logic [CNT_W-1:0] h_cnt, v_cnt;

    rtg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl(ctrl), .sync_cfg(sync_cfg), .disp_off(disp_off), .tim(tim)
    );

    rtg_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(ctrl.enable),
        .h_total(tim[TI_H_TOTAL]), .v_total(tim[TI_V_TOTAL]),
        .h_cnt(h_cnt), .v_cnt(v_cnt)
    );

    rtg_outstage #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst(rst), .ctrl(ctrl), .sync_cfg(sync_cfg),
        .disp_off(disp_off), .h_cnt(h_cnt), .v_cnt(v_cnt), .tim(tim),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .disp_active_o(disp_active_o),
        .video_on_o(video_on_o), .prefetch_o(prefetch_o),
        .sync_on_rgb_o(sync_on_rgb_o)
    );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl,
    input sync_cfg_t        sync_cfg,
    input logic             disp_off,
    input logic [CNT_W-1:0] h_cnt,
    input logic [CNT_W-1:0] v_cnt,
    input logic [CNT_W-1:0] h_total,
    input logic [CNT_W-1:0] v_total,
    input logic [CNT_W-1:0] h_disp,
    input logic [CNT_W-1:0] prefetch,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             disp_active_o,
    input logic             video_on_o,
    input logic             prefetch_o
);

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (h_cnt == '0 && v_cnt == '0));

    a_r3_h_wrap: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && h_cnt == h_total) |=> h_cnt == '0);

    a_r3_v_step: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && h_cnt == h_total && v_cnt < v_total)
        |=> v_cnt == $past(v_cnt) + CNT_W'(1));

    a_r6_outside_width: assert property (@(posedge clk) disable iff (rst)
        (h_cnt > h_disp) |=> !disp_active_o);

    a_r6_needs_refresh: assert property (@(posedge clk) disable iff (rst)
        !ctrl.refresh |=> !disp_active_o);

    a_r7_strobe_point: assert property (@(posedge clk) disable iff (rst)
        prefetch_o |-> $past(h_cnt) == $past(prefetch));

    a_r9_hsync_kill: assert property (@(posedge clk) disable iff (rst)
        (sync_cfg.h_off || sync_cfg.all_off) |=> hsync_o == $past(sync_cfg.h_inv));

    a_r9_vsync_kill: assert property (@(posedge clk) disable iff (rst)
        (sync_cfg.v_off || sync_cfg.all_off) |=> vsync_o == $past(sync_cfg.v_inv));

    a_r10_display_off: assert property (@(posedge clk) disable iff (rst)
        disp_off |=> !video_on_o);

endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sync_cfg(sync_cfg), .disp_off(disp_off),
    .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_total(tim[rtg_pkg::TI_H_TOTAL]), .v_total(tim[rtg_pkg::TI_V_TOTAL]),
    .h_disp(tim[rtg_pkg::TI_H_DISP]), .prefetch(tim[rtg_pkg::TI_PREFETCH]),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .disp_active_o(disp_active_o),
    .video_on_o(video_on_o), .prefetch_o(prefetch_o)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 12;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int WATCHDOG = 190000;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic hsync_o, vsync_o, disp_active_o, video_on_o, prefetch_o, sync_on_rgb_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    typedef struct {
        int htot, hd, hsb, hsf, hsf2, vtot, vd, vsb, vsf, pf;
    } cfg_t;

    raster_timing_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .disp_active_o(disp_active_o), .video_on_o(video_on_o),
        .prefetch_o(prefetch_o), .sync_on_rgb_o(sync_on_rgb_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input longint d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input int a, input longint exp, input string tag);
        @(negedge clk);
        rd_addr = ADDR_W'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic program_cfg(input cfg_t c);
        wr(0, 0);
        wr(1, c.htot);  wr(2, c.hd);   wr(3, c.hsb);  wr(4, c.hsf);
        wr(5, c.hsf2);  wr(6, c.vtot); wr(7, c.vd);   wr(8, c.vsb);
        wr(9, c.vsf);   wr(10, c.pf);
        wr(0, 3);
    endtask

    function automatic int frame_len(input cfg_t c);
        return (c.htot + 1) * (c.vtot + 1);
    endfunction
    function automatic int exp_hs(input cfg_t c);
        int e = (c.hsf < c.hsf2) ? c.hsf : c.hsf2;
        return (c.vtot + 1) * (e - c.hsb + 1);
    endfunction
    function automatic int exp_vs(input cfg_t c);
        return (c.htot + 1) * (c.vsf - c.vsb + 1);
    endfunction
    function automatic int exp_act(input cfg_t c);
        return (c.hd + 1) * (c.vd + 1);
    endfunction

    // counts over a window of n cycles; one settle cycle first
    task automatic measure(input int n, output int hs, output int vs, output int act,
                           output int vid, output int pf, output int hr);
        logic prev;
        hs = 0; vs = 0; act = 0; vid = 0; pf = 0; hr = 0;
        @(negedge clk);
        prev = hsync_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hs  += int'(hsync_o);
            vs  += int'(vsync_o);
            act += int'(disp_active_o);
            vid += int'(video_on_o);
            pf  += int'(prefetch_o);
            if (!prev && hsync_o) hr++;
            prev = hsync_o;
        end
    endtask

    task automatic run_cfg(input cfg_t c, input string name);
        int hs, vs, act, vid, pf, hr;
        program_cfg(c);
        measure(frame_len(c), hs, vs, act, vid, pf, hr);
        chk({name, " R4 hsync cycles/frame"}, hs, exp_hs(c));
        chk({name, " R5 vsync cycles/frame"}, vs, exp_vs(c));
        chk({name, " R6 active cycles/frame"}, act, exp_act(c));
        chk({name, " R10 video_on follows active"}, vid, exp_act(c));
        chk({name, " R7 strobes/frame"}, pf, c.vtot + 1);
        chk({name, " R3 lines/frame"}, hr, c.vtot + 1);
    endtask

    task automatic wait_hs_rise(output int n);
        logic prev;
        n = 0;
        prev = hsync_o;
        forever begin
            @(negedge clk);
            n++;
            if (!prev && hsync_o) break;
            prev = hsync_o;
        end
    endtask

    function automatic cfg_t rand_cfg();
        cfg_t c;
        c.hd   = 4 + int'($urandom % 8);
        c.hsb  = c.hd + 1 + int'($urandom % 3);
        c.hsf  = c.hsb + int'($urandom % 4);
        c.hsf2 = c.hsf;
        c.htot = c.hsf + 1 + int'($urandom % 5);
        c.pf   = int'($urandom % (c.htot + 1));
        c.vd   = 1 + int'($urandom % 3);
        c.vsb  = c.vd + 1 + int'($urandom % 2);
        c.vsf  = c.vsb + int'($urandom % 2);
        c.vtot = c.vsf + 1 + int'($urandom % 2);
        return c;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_t dm, c;
        int hs, vs, act, vid, pf, hr, n, f;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and readback
        rdchk(0, 0, "R1 control reset");
        rdchk(1, 0, "R1 h_total reset");
        rdchk(11, 0, "R1 sync control reset");
        chk("R2 hsync at reset", hsync_o, 0);
        chk("R6 active at reset", disp_active_o, 0);
        wr(7, 'h5a5);
        rdchk(7, 'h5a5, "R1 display height readback");
        wr(11, 'h7f);
        rdchk(11, 'h7b, "R1 sync control bit 2 reads zero");
        wr(11, 0);

        // default horizontal timing, shortened frame
        dm.htot = 1687; dm.hd = 1279; dm.hsb = 1327; dm.hsf = 1439; dm.hsf2 = 1439;
        dm.vtot = 11; dm.vd = 5; dm.vsb = 6; dm.vsf = 8; dm.pf = 1332;
        run_cfg(dm, "default");
        wait_hs_rise(n);
        n = 0;
        while (!prefetch_o) begin @(negedge clk); n++; end
        chk("R7 strobe offset from hsync start", n, dm.pf - dm.hsb);
        wait_hs_rise(n);
        wait_hs_rise(n);
        chk("R3 line period", n, dm.htot + 1);

        // random geometries
        for (int k = 0; k < 6; k++) begin
            c = rand_cfg();
            run_cfg(c, $sformatf("rand%0d", k));
        end

        // second hsync end compare shortens the pulse
        c = rand_cfg();
        c.hsf = c.hsb + 3; c.hsf2 = c.hsb + 1; c.htot = c.hsf + 2;
        c.pf = c.hd;
        run_cfg(c, "fin2");

        // output stage bits on a small geometry
        c = rand_cfg();
        program_cfg(c);
        f = frame_len(c);
        wr(11, 1 << 3);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R8 hsync inverted", hs, f - exp_hs(c));
        chk("R8 vsync unaffected by h invert", vs, exp_vs(c));
        wr(11, 1 << 4);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R8 vsync inverted", vs, f - exp_vs(c));
        wr(11, 1 << 5);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R9 hsync suppressed", hs, 0);
        chk("R9 vsync kept while hsync off", vs, exp_vs(c));
        wr(11, (1 << 5) | (1 << 3));
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R9 suppressed inverted hsync idles high", hs, f);
        wr(11, 1 << 6);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R9 vsync suppressed", vs, 0);
        chk("R9 hsync kept while vsync off", hs, exp_hs(c));
        wr(11, 1 << 1);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R9 all sync off hsync", hs, 0);
        chk("R9 all sync off vsync", vs, 0);
        wr(11, 1);
        @(negedge clk);
        chk("R10 sync on rgb flag", sync_on_rgb_o, 1);
        wr(11, 0);
        @(negedge clk);
        chk("R10 sync on rgb cleared", sync_on_rgb_o, 0);

        wr(12, 2);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R10 display off blanks video", vid, 0);
        chk("R10 display off keeps active", act, exp_act(c));
        wr(12, 0);

        wr(0, 1);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R6 refresh off no active", act, 0);
        chk("R7 refresh off no strobe", pf, 0);
        chk("R3 refresh off syncs run", hr, c.vtot + 1);

        wr(0, 2);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R2 disabled hsync", hs, 0);
        chk("R2 disabled vsync", vs, 0);
        chk("R2 disabled active", act, 0);
        wr(11, 1 << 3);
        measure(f, hs, vs, act, vid, pf, hr);
        chk("R2 disabled inverted hsync inactive high", hs, f);
        wr(11, 0);
        wr(0, 3);
        n = 0;
        while (!hsync_o) begin @(negedge clk); n++; end
        chk("R2 first hsync after enable", n, c.hsb + 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule